// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Beat Order

This block produces the address that a synchronous burst memory uses on each beat of a four-beat burst. A burst begins when either of two start strobes is sampled on a rising clock edge. One strobe belongs to the processor side and one to the memory-controller side. The address on the address input is then captured as the burst base and an internal beat counter is cleared. After the start, the address pins are no longer consulted. Each clock edge on which the advance input is high moves the burst on by one beat.

The low address bits, as wide as the beat counter, are formed from the base and the beat count. A static order input chooses between a linear order and an interleaved order. The order input is not registered, so it acts on the output directly. The upper address bits keep the base value for the whole burst. When the counter steps past the last beat it returns to zero, so the address returns to the base, and a wrap flag is high for exactly that one cycle. An output also reports which strobe started the current burst. This output makes the fixed priority between the two strobes visible.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is held and after it is released with no other stimulus, mem_addr_o is 0, wrap_o is 0 and from_cpu_o is 0.
- R2: When cpu_start_i or ctl_start_i is high at a rising edge, mem_addr_o equals the addr_i value sampled at that edge from the following cycle on. This holds whatever order_sel_i is, because the beat count is zero.
- R3: from_cpu_o is 1 after a start with cpu_start_i high (alone, or together with ctl_start_i), and 0 after a start with only ctl_start_i high.
- R4: When a strobe and adv_i are high at the same edge, the load wins: the output equals the new addr_i and the beat count is not stepped.
- R5: With order_sel_i = 0 (linear), after n advances since the start the low CNT_W bits equal (base_low + n) modulo 2^CNT_W.
- R6: With order_sel_i = 1 (interleaved), after n advances since the start the low CNT_W bits equal base_low XOR n.
- R7: Between strobes, the bits of mem_addr_o above the low CNT_W bits keep the base value. A carry out of the low bits never reaches them.
- R8: An edge with no strobe and adv_i low leaves mem_addr_o unchanged, given a constant order_sel_i.
- R9: Advancing from the last beat (count 2^CNT_W-1) returns the count to zero, so mem_addr_o returns to the base. wrap_o is 1 in the cycle after that edge only.
- R10: order_sel_i acts combinationally. Changing it in mid-burst changes the low bits of mem_addr_o with no clock edge.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_start_i | input | 1 | Processor-side burst start strobe; has priority |
| ctl_start_i | input | 1 | Controller-side burst start strobe |
| adv_i | input | 1 | Step the burst by one beat |
| addr_i | input | ADDR_W | Base address, sampled on a start |
| order_sel_i | input | 1 | 0 = linear order, 1 = interleaved order (not registered) |
| mem_addr_o | output | ADDR_W | Address for the current beat |
| wrap_o | output | 1 | One-cycle flag after the count wraps to zero |
| from_cpu_o | output | 1 | 1 when the current burst was started by cpu_start_i |

## Verification
The bench builds the block with ADDR_W = 6 and the default CNT_W = 2. At that size every one of the 64 base addresses can be run through a complete burst in both orders, with the starting strobe alternating between the two sides. This covers every starting low-bit value, every wrap back to the base and every upper-bit pattern, which would show a carry out of the low bits. Separate bursts cover both strobes at once, a strobe together with an advance, idle cycles, and an order flip in mid-burst.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

endpackage

// File: rtl/bsq_strobe_arb.sv
// Combines the two start strobes; the processor side has fixed priority.
module bsq_strobe_arb (
  input  logic cpu_start_i,
  input  logic ctl_start_i,
  output logic load_o,
  output logic sel_cpu_o
);

  always_comb begin
    load_o    = 1'b0;
    sel_cpu_o = 1'b0;
    if (cpu_start_i) begin
      load_o    = 1'b1;
      sel_cpu_o = 1'b1;
    end else if (ctl_start_i) begin
      load_o    = 1'b1;
      sel_cpu_o = 1'b0;
    end
  end

endmodule

// File: rtl/bsq_beat_counter.sv
// Beat counter: cleared on load, stepped on advance, flags the wrap to zero.
module bsq_beat_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] LAST_BEAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (step_i) begin
      cnt_q  <= cnt_q + 1'b1;
      wrap_q <= (cnt_q == LAST_BEAT);
    end else begin
      wrap_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

endmodule

// File: rtl/bsq_order_map.sv
// Maps base low bits and beat count to the beat's low address bits.
module bsq_order_map
  import bsq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] base_lo_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  burst_order_e     order_i,
  output logic [CNT_W-1:0] lo_o
);

  function automatic logic [CNT_W-1:0] linear_beat(
    input logic [CNT_W-1:0] base,
    input logic [CNT_W-1:0] beat
  );
    return base + beat;
  endfunction

  function automatic logic [CNT_W-1:0] interleave_beat(
    input logic [CNT_W-1:0] base,
    input logic [CNT_W-1:0] beat
  );
    return base ^ beat;
  endfunction

  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: lo_o = interleave_beat(base_lo_i, cnt_i);
      default:        lo_o = linear_beat(base_lo_i, cnt_i);
    endcase
  end

endmodule

// File: rtl/burst_addr_seq.sv
// Burst address sequencer: base register, beat counter and order mapping.
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_start_i,
  input  logic              ctl_start_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              order_sel_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              wrap_o,
  output logic              from_cpu_o
);

  localparam int HI_W = ADDR_W - CNT_W;

  // Named internal events, brought out for the checker.
  logic             load_w;
  logic             sel_cpu_w;
  logic             step_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] lo_w;

  logic [ADDR_W-1:0] base_q;
  logic              src_q;

  bsq_strobe_arb u_arb (
    .cpu_start_i (cpu_start_i),
    .ctl_start_i (ctl_start_i),
    .load_o      (load_w),
    .sel_cpu_o   (sel_cpu_w)
  );

  assign step_w = adv_i & ~load_w;

  bsq_beat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_w),
    .step_i (step_w),
    .cnt_o  (cnt_w),
    .wrap_o (wrap_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      src_q  <= 1'b0;
    end else if (load_w) begin
      base_q <= addr_i;
      src_q  <= sel_cpu_w;
    end
  end

  bsq_order_map #(.CNT_W(CNT_W)) u_map (
    .base_lo_i (base_q[CNT_W-1:0]),
    .cnt_i     (cnt_w),
    .order_i   (burst_order_e'(order_sel_i)),
    .lo_o      (lo_w)
  );

  assign mem_addr_o = {base_q[ADDR_W-1 -: HI_W], lo_w};
  assign from_cpu_o = src_q;

endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_start_i,
  input logic              ctl_start_i,
  input logic              adv_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              order_sel_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              wrap_o,
  input logic              from_cpu_o,
  input logic              step_w,
  input logic [CNT_W-1:0]  cnt_w
);

  localparam logic [CNT_W-1:0] LAST_BEAT = {CNT_W{1'b1}};

  // R2 / R4: a start loads addr_i, even with adv_i high at the same edge.
  a_r2_start_loads_base: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_start_i || ctl_start_i) |=> (mem_addr_o == $past(addr_i)));

  // R3: processor strobe has priority.
  a_r3_cpu_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_start_i |=> from_cpu_o);

  a_r3_ctl_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_start_i && !cpu_start_i) |=> !from_cpu_o);

  // R7: upper bits fixed between strobes.
  a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_start_i || ctl_start_i) |=> $stable(mem_addr_o[ADDR_W-1:CNT_W]));

  // R8: idle edge holds the address.
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_start_i && !ctl_start_i && !adv_i)
      |=> ($stable(order_sel_i) -> $stable(mem_addr_o)));

  // R9: wrap is a single-cycle pulse, caused by stepping off the last beat.
  a_r9_wrap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> !wrap_o);

  a_r9_wrap_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> (cnt_w == '0));

  a_r9_wrap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && cnt_w == LAST_BEAT) |=> wrap_o);

endmodule

bind burst_addr_seq bsq_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_start_i (cpu_start_i),
  .ctl_start_i (ctl_start_i),
  .adv_i       (adv_i),
  .addr_i      (addr_i),
  .order_sel_i (order_sel_i),
  .mem_addr_o  (mem_addr_o),
  .wrap_o      (wrap_o),
  .from_cpu_o  (from_cpu_o),
  .step_w      (step_w),
  .cnt_w       (cnt_w)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;

  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_start_i, ctl_start_i, adv_i, order_sel_i;
  logic [AW-1:0] addr_i;
  logic [AW-1:0] mem_addr_o;
  logic          wrap_o, from_cpu_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .CNT_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_start_i(cpu_start_i), .ctl_start_i(ctl_start_i),
    .adv_i(adv_i), .addr_i(addr_i), .order_sel_i(order_sel_i),
    .mem_addr_o(mem_addr_o), .wrap_o(wrap_o), .from_cpu_o(from_cpu_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected address computed arithmetically from the requirements.
  function automatic int beat_addr(input int base, input int n, input bit ilv);
    int hi = (base / 4) * 4;
    int lo = base % 4;
    if (ilv) return hi + (lo ^ (n % 4));
    return hi + ((lo + n) % 4);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic start(input int base, input bit cpu, input bit ctl, input bit adv);
    addr_i = AW'(base); cpu_start_i = cpu; ctl_start_i = ctl; adv_i = adv;
    tick();
    cpu_start_i = 1'b0; ctl_start_i = 1'b0; adv_i = 1'b0;
    addr_i = ~AW'(base);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_start_i = 0; ctl_start_i = 0; adv_i = 0;
    addr_i = '0; order_sel_i = 0;
    repeat (3) tick();
    check("R1 addr in reset", mem_addr_o, 0);
    check("R1 wrap in reset", wrap_o, 0);
    rst_n = 1'b1;
    tick();
    check("R1 addr after reset", mem_addr_o, 0);
    check("R1 wrap after reset", wrap_o, 0);
    check("R1 src after reset", from_cpu_o, 0);

    // Full sweep: every base, both orders, alternating strobe side.
    for (int ilv = 0; ilv < 2; ilv++) begin
      for (int b = 0; b < (1 << AW); b++) begin
        bit use_cpu = b[0];
        order_sel_i = ilv[0];
        start(b, use_cpu, !use_cpu, 1'b0);
        check("R2 base after start", mem_addr_o, b);
        check("R3 start source", from_cpu_o, use_cpu);
        for (int n = 1; n < 4; n++) begin
          adv_i = 1'b1;
          tick();
          check(ilv ? "R6 interleaved beat" : "R5 linear beat",
                mem_addr_o, beat_addr(b, n, ilv[0]));
          check("R7 upper bits", mem_addr_o / 4, b / 4);
          check("R9 no early wrap", wrap_o, 0);
        end
        tick();
        adv_i = 1'b0;
        check("R9 back to base", mem_addr_o, b);
        check("R9 wrap pulse", wrap_o, 1);
        tick();
        check("R9 wrap one cycle", wrap_o, 0);
        check("R8 idle hold", mem_addr_o, b);
      end
    end

    // R3: both strobes together, processor wins.
    order_sel_i = 1'b0;
    start(13, 1'b1, 1'b1, 1'b0);
    check("R3 both strobes src", from_cpu_o, 1);
    check("R2 both strobes base", mem_addr_o, 13);
    start(22, 1'b0, 1'b1, 1'b0);
    check("R3 ctl alone src", from_cpu_o, 0);

    // R4: strobe with advance at the same edge loads, count not stepped.
    adv_i = 1'b1; tick(); adv_i = 1'b0;  // mid-burst of 22
    start(39, 1'b0, 1'b1, 1'b1);
    check("R4 load over advance", mem_addr_o, 39);
    adv_i = 1'b1; tick(); adv_i = 1'b0;
    check("R4 count cleared", mem_addr_o, beat_addr(39, 1, 1'b0));

    // R8: several idle cycles hold.
    repeat (3) tick();
    check("R8 multi idle hold", mem_addr_o, beat_addr(39, 1, 1'b0));

    // R10: order flips act without a clock. Base 39 low=3, count 1.
    order_sel_i = 1'b1; #1;
    check("R10 flip to interleaved", mem_addr_o, beat_addr(39, 1, 1'b1));
    order_sel_i = 1'b0; #1;
    check("R10 flip to linear", mem_addr_o, beat_addr(39, 1, 1'b0));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule